// File: doc/BRIEF.md
# DMA Burst Sequencer

This block schedules data movement for a small set of DMA channels. Each channel owns a peripheral trigger line, an arm strobe, a burst length, a transfer length and three mode bits: one-shot, interrupt enable and interrupt timing. The sequencer latches triggers, picks a channel by rotating priority, and then issues one word strobe per clock for each word of the burst. Every strobe is tagged with the number of the channel being served. Around the strobes it emits the transfer-start, burst-end and transfer-end events that a separate address generator consumes. It also raises a one-cycle CPU interrupt per transfer when that interrupt is enabled.

A transfer is made of two nested counts. The inner count covers the words of one burst. The outer count covers the bursts of one transfer. With one-shot clear, each trigger buys one burst, and the channel gives up the engine after that burst. With one-shot set, a single trigger carries the channel through every remaining burst with no gap. Once a transfer completes, the channel goes dormant until software arms it again.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, no word strobe, no event, no interrupt and no overflow error is asserted.
- R2: A trigger sets the channel's pending flag at the next clock edge. A pending channel that is armed is granted in an arbitration cycle with no word strobe. Its words then follow on consecutive cycles, with `word_ch_o` holding the channel number throughout.
- R3: A transfer has `xfer_len_i+1` bursts. `start_xfer_o` is high with the first word of the first burst. `burst_done_o` is high with the last word of every burst. `xfer_done_o` is high with the last word of the last burst.
- R4: With one-shot clear, the cycle after any burst that does not end the transfer carries no word strobe. The next grant goes through arbitration, even if the same channel is pending again.
- R5: Arbitration is rotating. The search starts at the channel after the one most recently granted and wraps past the highest index. After reset the search begins at channel 0.
- R6: With one-shot set, one trigger runs all bursts of the transfer on back-to-back cycles for that channel, and no other channel is served in between.
- R7: With `irq_en_i` set, exactly one `irq_o` pulse is raised for the channel per transfer. It coincides with `start_xfer_o` when `irq_at_start_i` is 1, and with `xfer_done_o` when it is 0. With `irq_en_i` clear, no pulse is raised.
- R8: A trigger that arrives while the channel's pending flag is set, and is not being consumed by a grant in that cycle, sets the channel's sticky `ovf_err_o`. A trigger in the grant cycle is kept as a new pending request without error. Only an effective arm clears the error.
- R9: After its transfer completes, a channel is not served until `arm_i` is pulsed. An effective arm (channel not running) clears the pending flag, the error and the burst count. An arm pulse while the channel is running has no effect.
- R10: A burst length field of value n gives n+1 words. The 5-bit field allows 1 to 32 words. The 16-bit transfer field counts bursts in the same n+1 way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | NUM_CH | Per-channel peripheral trigger pulse |
| arm_i | input | NUM_CH | Per-channel arm strobe starting a new transfer |
| oneshot_i | input | NUM_CH | Run the whole transfer on one trigger |
| irq_en_i | input | NUM_CH | Interrupt enable |
| irq_at_start_i | input | NUM_CH | 1: interrupt at transfer start, 0: at transfer end |
| burst_len_i | input | NUM_CH x BLEN_W | Words per burst minus one |
| xfer_len_i | input | NUM_CH x XFER_W | Bursts per transfer minus one |
| word_o | output | 1 | One word is moved this cycle |
| word_ch_o | output | CH_W | Channel of the current word |
| start_xfer_o | output | 1 | First word of a transfer |
| burst_done_o | output | 1 | Last word of a burst |
| xfer_done_o | output | 1 | Last word of a transfer |
| irq_o | output | NUM_CH | Per-channel CPU interrupt pulse |
| ovf_err_o | output | NUM_CH | Sticky trigger overflow error |

## Verification
Two pairs of functions can fall in the same clock. The first is a new trigger that lands in the very cycle a grant consumes that channel's pending flag. That case must leave the flag set with no overflow error. The second is a one-word, one-burst transfer, where start and end events (and either interrupt timing) share the only word cycle. Directed cases place a trigger exactly on the grant cycle and run minimum-length transfers. Long random runs with dense triggers and zero-length fields hit both cases again. A cycle-by-cycle bench model derived from the requirements judges every output in every cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    // Events the sequencer core hands to one channel's control slice each cycle
    typedef struct packed {
        logic arm;        // software arm strobe
        logic trig;       // peripheral trigger
        logic grant;      // channel wins arbitration this cycle
        logic burst_end;  // last word of a burst for this channel
        logic xfer_end;   // last word of the transfer for this channel
    } chan_evt_t;

endpackage

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_seq_pkg::*;
#(
    parameter int XFER_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  chan_evt_t         evt_i,
    output logic              pending_o,
    output logic              running_o,
    output logic              err_o,
    output logic [XFER_W-1:0] bcnt_o
);

    typedef struct packed {
        logic              pend;
        logic              run;
        logic              err;
        logic [XFER_W-1:0] bcnt;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     arm_eff;

    assign arm_eff = evt_i.arm && !st_q.run;

    always_comb begin
        st_d = st_q;
        if (arm_eff) begin
            st_d.pend = 1'b0;
            st_d.err  = 1'b0;
            st_d.bcnt = '0;
            st_d.run  = 1'b1;
        end else begin
            st_d.err  = st_q.err || (evt_i.trig && st_q.pend && !evt_i.grant);
            st_d.pend = (st_q.pend && !evt_i.grant) || evt_i.trig;
            if (evt_i.xfer_end) begin
                st_d.bcnt = '0;
                st_d.run  = 1'b0;
            end else if (evt_i.burst_end) begin
                st_d.bcnt = st_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pend <= 1'b0;
            st_q.run  <= 1'b0;
            st_q.err  <= 1'b0;
            st_q.bcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pend;
    assign running_o = st_q.run;
    assign err_o     = st_q.err;
    assign bcnt_o    = st_q.bcnt;

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i.grant |-> (pending_o && running_o)); // R2
    AST_DORMANT_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i.xfer_end |=> !running_o); // R9
    AST_ARM_WHILE_RUN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i.arm && running_o && !evt_i.xfer_end) |=> (running_o && $stable(bcnt_o) || $past(evt_i.burst_end))); // R9
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !evt_i.arm) |=> err_o); // R8

endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [CH_W-1:0]   last_i,
    output logic              gnt_vld_o,
    output logic [CH_W-1:0]   gnt_idx_o
);

    // Search begins one past the last grant and wraps around
    always_comb begin
        gnt_vld_o = 1'b0;
        gnt_idx_o = '0;
        for (int k = 1; k <= NUM_CH; k++) begin
            int idx;
            idx = (int'(last_i) + k) % NUM_CH;
            if (!gnt_vld_o && req_i[idx]) begin
                gnt_vld_o = 1'b1;
                gnt_idx_o = CH_W'(idx);
            end
        end
    end

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int BLEN_W = 5,
    parameter int XFER_W = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [NUM_CH-1:0]              trig_i,
    input  logic [NUM_CH-1:0]              arm_i,
    input  logic [NUM_CH-1:0]              oneshot_i,
    input  logic [NUM_CH-1:0]              irq_en_i,
    input  logic [NUM_CH-1:0]              irq_at_start_i,
    input  logic [NUM_CH-1:0][BLEN_W-1:0]  burst_len_i,
    input  logic [NUM_CH-1:0][XFER_W-1:0]  xfer_len_i,
    output logic                           word_o,
    output logic [CH_W-1:0]                word_ch_o,
    output logic                           start_xfer_o,
    output logic                           burst_done_o,
    output logic                           xfer_done_o,
    output logic [NUM_CH-1:0]              irq_o,
    output logic [NUM_CH-1:0]              ovf_err_o
);

    typedef struct packed {
        logic              act;
        logic [CH_W-1:0]   ch;
        logic [CH_W-1:0]   last;
        logic [BLEN_W-1:0] wcnt;
    } seq_st_t;

    seq_st_t                     st_d, st_q;
    logic [NUM_CH-1:0]           pend_w, run_w, elig_w;
    logic [NUM_CH-1:0][XFER_W-1:0] bcnt_w;
    logic                        gnt_vld;
    logic [CH_W-1:0]             gnt_idx;
    logic                        grant_any;
    logic                        at_bend, at_first, at_xend;
    logic [BLEN_W-1:0]           cur_blen;
    logic [XFER_W-1:0]           cur_bcnt, cur_xlen;

    assign elig_w    = pend_w & run_w;
    assign grant_any = !st_q.act && gnt_vld;

    dma_rr_arb #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_arb (
        .req_i     (elig_w),
        .last_i    (st_q.last),
        .gnt_vld_o (gnt_vld),
        .gnt_idx_o (gnt_idx)
    );

    assign cur_blen = burst_len_i[st_q.ch];
    assign cur_xlen = xfer_len_i[st_q.ch];
    assign cur_bcnt = bcnt_w[st_q.ch];
    assign at_bend  = st_q.act && (st_q.wcnt == cur_blen);
    assign at_first = st_q.act && (st_q.wcnt == '0) && (cur_bcnt == '0);
    assign at_xend  = at_bend && (cur_bcnt == cur_xlen);

    always_comb begin
        st_d = st_q;
        if (st_q.act) begin
            if (at_bend) begin
                st_d.wcnt = '0;
                if (at_xend || !oneshot_i[st_q.ch]) begin
                    st_d.act = 1'b0;
                end
            end else begin
                st_d.wcnt = st_q.wcnt + 1'b1;
            end
        end else if (gnt_vld) begin
            st_d.act  = 1'b1;
            st_d.ch   = gnt_idx;
            st_d.last = gnt_idx;
            st_d.wcnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.act  <= 1'b0;
            st_q.ch   <= '0;
            st_q.last <= CH_W'(NUM_CH - 1);
            st_q.wcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        chan_evt_t evt;
        logic      is_cur;

        assign is_cur        = (st_q.ch == CH_W'(c));
        assign evt.arm       = arm_i[c];
        assign evt.trig      = trig_i[c];
        assign evt.grant     = grant_any && (gnt_idx == CH_W'(c));
        assign evt.burst_end = at_bend && is_cur;
        assign evt.xfer_end  = at_xend && is_cur;

        dma_chan_ctl #(
            .XFER_W (XFER_W)
        ) u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .evt_i     (evt),
            .pending_o (pend_w[c]),
            .running_o (run_w[c]),
            .err_o     (ovf_err_o[c]),
            .bcnt_o    (bcnt_w[c])
        );

        assign irq_o[c] = irq_en_i[c] && is_cur &&
                          (irq_at_start_i[c] ? at_first : at_xend);
    end

    assign word_o       = st_q.act;
    assign word_ch_o    = st_q.ch;
    assign start_xfer_o = at_first;
    assign burst_done_o = at_bend;
    assign xfer_done_o  = at_xend;

    AST_YIELD_AFTER_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_done_o && !xfer_done_o && !oneshot_i[word_ch_o]) |=> !word_o); // R4
    AST_ONESHOT_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_done_o && !xfer_done_o && oneshot_i[word_ch_o]) |=> (word_o && $stable(word_ch_o))); // R6
    AST_BURST_HOLDS_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_o && !burst_done_o) |=> (word_o && $stable(word_ch_o))); // R2
    AST_END_GOES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_done_o |=> !word_o); // R9
    AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(irq_o)); // R7
    AST_IRQ_WITH_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_o) |-> (start_xfer_o || xfer_done_o)); // R7

endmodule

// File: tb/dma_burst_seq_bench.sv
module dma_burst_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int BLEN_W     = 5;
    localparam int XFER_W     = 16;
    localparam int CH_W       = 2;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic [NUM_CH-1:0]             trig = '0, arm = '0, oneshot = '0, irq_en = '0, at_start = '0;
    logic [NUM_CH-1:0][BLEN_W-1:0] blen = '0;
    logic [NUM_CH-1:0][XFER_W-1:0] xlen = '0;
    logic                          word, start_x, bdone, xdone;
    logic [CH_W-1:0]               wch;
    logic [NUM_CH-1:0]             irq, err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_burst_seq #(
        .NUM_CH (NUM_CH),
        .BLEN_W (BLEN_W),
        .XFER_W (XFER_W)
    ) u_dma_burst_seq (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .trig_i         (trig),
        .arm_i          (arm),
        .oneshot_i      (oneshot),
        .irq_en_i       (irq_en),
        .irq_at_start_i (at_start),
        .burst_len_i    (blen),
        .xfer_len_i     (xlen),
        .word_o         (word),
        .word_ch_o      (wch),
        .start_xfer_o   (start_x),
        .burst_done_o   (bdone),
        .xfer_done_o    (xdone),
        .irq_o          (irq),
        .ovf_err_o      (err)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // Bench model state
    bit m_pend[NUM_CH], m_run[NUM_CH], m_err[NUM_CH];
    int m_bcnt[NUM_CH];
    bit m_act;
    int m_ch, m_last, m_wcnt;

    // Observation counters
    int n_word[NUM_CH];
    int n_bdone, n_xdone, n_start, n_irq, n_irq_start;
    int seq[16];
    int seq_n;
    int first_w, last_w;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int next_blen();
        return (($urandom % 8) == 0) ? 31 : int'($urandom % 4);
    endfunction

    task automatic clear_stats();
        for (int c = 0; c < NUM_CH; c++) n_word[c] = 0;
        n_bdone = 0; n_xdone = 0; n_start = 0; n_irq = 0; n_irq_start = 0;
        seq_n = 0; first_w = -1; last_w = -1;
    endtask

    task automatic model_reset();
        for (int c = 0; c < NUM_CH; c++) begin
            m_pend[c] = 0; m_run[c] = 0; m_err[c] = 0; m_bcnt[c] = 0;
        end
        m_act = 0; m_ch = 0; m_last = NUM_CH - 1; m_wcnt = 0;
    endtask

    // Called just after a falling edge with inputs applied; compares, advances the model,
    // waits for the next falling edge and drops the one-cycle strobes.
    task automatic step();
        bit e_bend, e_first, e_xend;
        logic [NUM_CH-1:0] e_irq;
        int g;
        #1;
        e_bend  = m_act && (m_wcnt == int'(blen[m_ch]));
        e_first = m_act && (m_wcnt == 0) && (m_bcnt[m_ch] == 0);
        e_xend  = e_bend && (m_bcnt[m_ch] == int'(xlen[m_ch]));
        for (int c = 0; c < NUM_CH; c++)
            e_irq[c] = (m_ch == c) && irq_en[c] && (at_start[c] ? e_first : e_xend);
        chk(word == m_act, "R2 word_o", int'(word), int'(m_act));
        if (m_act) chk(int'(wch) == m_ch, "R2 word_ch_o", int'(wch), m_ch);
        chk(start_x == e_first, "R3 start_xfer_o", int'(start_x), int'(e_first));
        chk(bdone == e_bend, "R3 burst_done_o", int'(bdone), int'(e_bend));
        chk(xdone == e_xend, "R3 xfer_done_o", int'(xdone), int'(e_xend));
        chk(irq == e_irq, "R7 irq_o", int'(irq), int'(e_irq));
        for (int c = 0; c < NUM_CH; c++)
            chk(err[c] == m_err[c], "R8 ovf_err_o", int'(err[c]), int'(m_err[c]));
        // statistics from the ports
        if (word) begin
            n_word[wch]++;
            if (first_w < 0) first_w = cyc;
            last_w = cyc;
        end
        if (bdone) begin
            if (seq_n < 16) seq[seq_n] = int'(wch);
            seq_n++;
            n_bdone++;
        end
        if (xdone) n_xdone++;
        if (start_x) n_start++;
        if (|irq) n_irq++;
        if ((|irq) && start_x) n_irq_start++;
        // advance model
        g = -1;
        if (!m_act)
            for (int k = 1; k <= NUM_CH; k++) begin
                int idx;
                idx = (m_last + k) % NUM_CH;
                if (g < 0 && m_pend[idx] && m_run[idx]) g = idx;
            end
        for (int c = 0; c < NUM_CH; c++) begin
            bit gr, be, xe;
            gr = (g == c);
            be = e_bend && (m_ch == c);
            xe = e_xend && (m_ch == c);
            if (arm[c] && !m_run[c]) begin
                m_pend[c] = 0; m_err[c] = 0; m_bcnt[c] = 0; m_run[c] = 1;
            end else begin
                m_err[c]  = m_err[c] || (trig[c] && m_pend[c] && !gr);
                m_pend[c] = (m_pend[c] && !gr) || trig[c];
                if (xe) begin m_bcnt[c] = 0; m_run[c] = 0; end
                else if (be) m_bcnt[c]++;
            end
        end
        if (m_act) begin
            if (e_bend) begin
                m_wcnt = 0;
                if (e_xend || !oneshot[m_ch]) m_act = 0;
            end else m_wcnt++;
        end else if (g >= 0) begin
            m_act = 1; m_ch = g; m_last = g; m_wcnt = 0;
        end
        @(negedge clk);
        cyc++;
        trig = '0;
        arm  = '0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        trig = '0; arm = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_stats();
    endtask

    task automatic cfg(input int c, input int bl, input int xl, input bit os,
                       input bit ie, input bit ats);
        blen[c] = BLEN_W'(bl); xlen[c] = XFER_W'(xl);
        oneshot[c] = os; irq_en[c] = ie; at_start[c] = ats;
    endtask

    initial begin : main
        // R1: reset state
        do_reset();
        #1;
        chk(word == 1'b0, "R1 word_o after reset", int'(word), 0);
        chk(irq == '0, "R1 irq_o after reset", int'(irq), 0);
        chk(err == '0, "R1 ovf_err_o after reset", int'(err), 0);
        chk({start_x, bdone, xdone} == 3'b000, "R1 events after reset", int'({start_x, bdone, xdone}), 0);
        steps(2);

        // R10 / R3 / R7 / R9: full 32-word burst, single-burst transfer, then dormant
        do_reset();
        cfg(0, 31, 0, 0, 1, 0);
        arm[0] = 1; step();
        trig[0] = 1; step();
        steps(40);
        chk(n_word[0] == 32, "R10 words in max burst", n_word[0], 32);
        chk(n_bdone == 1, "R3 bursts", n_bdone, 1);
        chk(n_xdone == 1, "R3 transfers", n_xdone, 1);
        chk(n_irq == 1, "R7 end interrupt count", n_irq, 1);
        trig[0] = 1; step();
        steps(10);
        chk(n_word[0] == 32, "R9 dormant after transfer", n_word[0], 32);
        arm[0] = 1; step();
        steps(10);
        chk(n_word[0] == 32, "R9 arm clears stale trigger", n_word[0], 32);

        // R4 / R5: two channels interleave per burst
        do_reset();
        cfg(0, 1, 1, 0, 0, 0);
        cfg(2, 1, 1, 0, 0, 0);
        arm[0] = 1; arm[2] = 1; step();
        trig[0] = 1; trig[2] = 1; step();   // grant ch0 next cycle
        step();                              // grant cycle
        trig[0] = 1; step();                 // ch0 word 0
        steps(2);                            // ch0 word 1, arbitration
        trig[2] = 1; step();                 // ch2 word 0 (ch2 pending consumed)
        steps(20);
        chk(seq_n == 4, "R4 burst count", seq_n, 4);
        chk(seq[0] == 0, "R5 first grant from channel 0", seq[0], 0);
        chk(seq[1] == 2, "R4 rotate away after burst", seq[1], 2);
        chk(seq[2] == 0, "R5 wrap to channel 0", seq[2], 0);
        chk(seq[3] == 2, "R5 channel 2 second burst", seq[3], 2);
        chk(n_xdone == 2, "R3 both transfers end", n_xdone, 2);
        chk(err == '0, "R8 no overflow in rotation", int'(err), 0);

        // R6 / R7: one-shot runs whole transfer back to back, start interrupt
        do_reset();
        cfg(1, 2, 3, 1, 1, 1);
        cfg(3, 0, 0, 0, 0, 0);
        arm[1] = 1; arm[3] = 1; step();
        trig[1] = 1; trig[3] = 1; step();
        steps(25);
        chk(n_word[1] == 12, "R6 one-shot word total", n_word[1], 12);
        chk(n_word[3] == 1, "R6 other channel after one-shot", n_word[3], 1);
        chk(seq_n >= 5 && seq[4] == 3, "R6 no interleave", seq_n >= 5 ? seq[4] : -1, 3);
        chk(n_irq_start == 1, "R7 start interrupt with start", n_irq_start, 1);

        // R8: trigger on the grant cycle is kept, then overflow is sticky
        do_reset();
        cfg(3, 0, 3, 0, 1, 1);
        arm[3] = 1; step();
        trig[3] = 1; step();
        trig[3] = 1; step();                 // lands on the grant cycle
        steps(6);
        chk(err[3] == 1'b0, "R8 grant-cycle trigger no error", int'(err[3]), 0);
        chk(n_word[3] == 2, "R8 grant-cycle trigger served", n_word[3], 2);
        chk(n_start == 1 && n_irq == 1, "R7 one-word start irq", n_irq, 1);
        trig[1] = 1; step();
        trig[1] = 1; step();
        steps(3);
        chk(err[1] == 1'b1, "R8 overflow sticky", int'(err[1]), 1);
        arm[1] = 1; step();
        #1;
        chk(err[1] == 1'b0, "R8 arm clears error", int'(err[1]), 0);
        steps(2);

        // R9: arm while running ignored
        do_reset();
        cfg(0, 0, 1, 0, 0, 0);
        arm[0] = 1; step();
        trig[0] = 1; step();
        steps(5);
        arm[0] = 1; step();
        trig[0] = 1; step();
        steps(5);
        chk(n_start == 1, "R9 arm while running ignored", n_start, 1);
        chk(n_xdone == 1, "R9 transfer continues", n_xdone, 1);

        // Random segments
        void'($urandom(32'h5eed_0d3a));
        for (int s = 0; s < 6; s++) begin
            do_reset();
            for (int c = 0; c < NUM_CH; c++)
                cfg(c, next_blen(), int'($urandom % 4), bit'($urandom % 2),
                    bit'($urandom % 2), bit'($urandom % 2));
            for (int i = 0; i < 2500; i++) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    trig[c] = (($urandom % 6) == 0);
                    arm[c]  = (($urandom % 20) == 0);
                end
                step();
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule